// File: doc/BRIEF.md
# PLL Ratio Search Engine

This block picks an input divider, a feedback multiplier and a post-divider for a clock synthesiser. It takes a reference frequency and a requested output frequency, both in integer Hz, and returns the settings whose output frequency is closest to the request. A one-cycle `start` pulse begins an operation. A one-cycle `done` pulse ends it, and at that point a set of mutually exclusive result flags says what happened.

Two configuration words decide whether a search takes place. A nonzero mode word means the clock is already configured, so the block reports a bypass. A zero mode word together with a zero frequency word means the clock is handled somewhere else. A zero mode word with a nonzero frequency word starts a search.

The search visits every (D, P, M) combination in a fixed order, one candidate per clock. It stops as soon as it finds an exact match. If it reaches the end without one, it returns the closest candidate within tolerance, or it reports a failure. The resulting settings are meant to be handed to whatever logic programs the synthesiser.

Top module: `pll_ratio_search`

## Requirements
- R1: When `start` is sampled while idle and `cfg_mode` is nonzero, `done` is high exactly one clock edge later. At that point `res_bypass`=1, every other result flag is 0, and `div_d`, `mul_m`, `post_p` and `out_hz` are 0.
- R2: When `start` is sampled while idle and both `cfg_mode` and `cfg_freq_hz` are zero, `done` is high one edge later with `res_external`=1 and every other flag and every setting at 0.
- R3: A search visits D = 1..D_MAX in the outermost loop, the post-divide index i = 0..P_CNT-1 in the middle loop and M = 1..M_MAX in the innermost loop, all ascending, one candidate per clock. Counting edges from the edge that samples `start`, `done` rises at edge k+2 when candidate index k (0-based, in scan order) is an exact match. With no exact match it rises at edge D_MAX*P_CNT*M_MAX+1. `busy` is high from edge 1 until the edge that raises `done`.
- R4: A candidate is valid only if its VCO frequency floor(ref/D)*M lies between VCO_MIN_HZ and VCO_MAX_HZ, both inclusive.
- R5: A candidate is valid only if its divided input floor(ref/D) is at least FIN_MIN_HZ.
- R6: A candidate's output is VCO >> i, which means P = 2^i. A valid candidate whose output equals the request ends the search with `res_exact`=1 and that candidate's D, M, P and output.
- R7: With no exact match, the result is the valid candidate with the smallest |output − request| among those whose error is at most TOL_HZ. A tie goes to the candidate visited first. The flags are `res_near`=1 and `res_exact`=0.
- R8: When no valid candidate is within tolerance, `res_fail`=1 and `div_d`, `mul_m`, `post_p` and `out_hz` are 0.
- R9: `done` lasts one cycle. After reset all outputs are 0. The settings and flags only change on the edge that raises `done`, and they hold their values afterwards.
- R10: While `busy` is high, `start` is ignored, and so are changes to `cfg_mode`, `cfg_freq_hz` and `ref_hz`. The request and the reference are captured when the search begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| cfg_mode | input | 32 | Clock-mode word; nonzero selects bypass |
| cfg_freq_hz | input | 32 | Requested output frequency in Hz |
| ref_hz | input | 32 | Reference frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| res_exact | output | 1 | Exact match found |
| res_near | output | 1 | Nearest in-tolerance candidate returned |
| res_fail | output | 1 | No candidate within tolerance |
| res_bypass | output | 1 | Search skipped, mode word nonzero |
| res_external | output | 1 | Search skipped, clock handled elsewhere |
| div_d | output | 7 | Input divider D |
| mul_m | output | 11 | Feedback multiplier M |
| post_p | output | 4 | Post-divider value P |
| out_hz | output | 32 | Achieved output frequency in Hz |

## Verification
A skipped search finishes one edge after `start`. A search finishes at edge k+2 after an exact hit at scan index k, and at edge D_MAX*P_CNT*M_MAX+1 after a full scan. The bench computes the expected edge beforehand with an independent loop model. On every falling edge it compares `done` and `busy` with what that cycle should show, and it reads the settings and flags only in the cycle where `done` is due. It then checks them once more in the following cycle to confirm that they hold.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int HZ_W   = 32;
    localparam int D_W    = 7;
    localparam int M_W    = 11;
    localparam int PI_W   = 2;
    localparam int POST_W = 1 << PI_W;
    localparam int VCO_W  = HZ_W + M_W + 5;
    localparam int ERR_W  = HZ_W + 1;

    localparam int DEF_VCO_MIN_HZ = 100_000_000;
    localparam int DEF_VCO_MAX_HZ = 350_000_000;
    localparam int DEF_FIN_MIN_HZ = 500_000;
    localparam int DEF_TOL_HZ     = 500_000;

    typedef enum logic [0:0] {ST_IDLE, ST_SCAN} scan_state_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_BYPASS,
        RK_EXTERNAL,
        RK_EXACT,
        RK_NEAR,
        RK_FAIL
    } result_kind_e;

    typedef struct packed {
        logic [D_W-1:0]   d;
        logic [PI_W-1:0]  pi;
        logic [M_W-1:0]   m;
        logic [HZ_W-1:0]  out_hz;
        logic [ERR_W-1:0] err;
    } cand_t;

    function automatic logic [VCO_W-1:0] abs_diff(input logic [VCO_W-1:0] a,
                                                  input logic [VCO_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pll_cand_iter.sv
module pll_cand_iter
    import pll_search_pkg::*;
#(
    parameter int D_MAX = 64,
    parameter int M_MAX = 1024,
    parameter int P_CNT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [HZ_W-1:0]  ref_now,
    input  logic [HZ_W-1:0]  ref_q,
    output logic [D_W-1:0]   d,
    output logic [PI_W-1:0]  pi,
    output logic [M_W-1:0]   m,
    output logic [HZ_W-1:0]  fin,
    output logic             last
);

    localparam logic [D_W-1:0]  D_TOP = D_W'(D_MAX);
    localparam logic [M_W-1:0]  M_TOP = M_W'(M_MAX);
    localparam logic [PI_W-1:0] P_TOP = PI_W'(P_CNT - 1);

    always_comb begin
        last = (d == D_TOP) && (pi == P_TOP) && (m == M_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d   <= D_W'(1);
            pi  <= '0;
            m   <= M_W'(1);
            fin <= '0;
        end else if (load) begin
            d   <= D_W'(1);
            pi  <= '0;
            m   <= M_W'(1);
            fin <= ref_now;
        end else if (step && !last) begin
            if (m == M_TOP) begin
                m <= M_W'(1);
                if (pi == P_TOP) begin
                    pi  <= '0;
                    d   <= d + D_W'(1);
                    fin <= ref_q / (HZ_W'(d) + HZ_W'(1));
                end else begin
                    pi <= pi + PI_W'(1);
                end
            end else begin
                m <= m + M_W'(1);
            end
        end
    end

    AST_ITER_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (d >= D_W'(1)) && (d <= D_TOP) && (m >= M_W'(1)) && (m <= M_TOP) && (pi <= P_TOP)); // R3

    AST_FIN_TRACKS_D: assert property (@(posedge clk) disable iff (rst)
        step && !last && (m == M_TOP) && (pi == P_TOP) |=> (fin == ref_q / HZ_W'(d))); // R5

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int VCO_MIN_HZ = DEF_VCO_MIN_HZ,
    parameter int VCO_MAX_HZ = DEF_VCO_MAX_HZ,
    parameter int FIN_MIN_HZ = DEF_FIN_MIN_HZ,
    parameter int TOL_HZ     = DEF_TOL_HZ
) (
    input  logic [HZ_W-1:0] fin,
    input  logic [D_W-1:0]  d,
    input  logic [PI_W-1:0] pi,
    input  logic [M_W-1:0]  m,
    input  logic [HZ_W-1:0] tgt,
    output cand_t           cand,
    output logic            valid,
    output logic            exact,
    output logic            within_tol
);

    logic [VCO_W-1:0] vco;
    logic [VCO_W-1:0] post;
    logic [VCO_W-1:0] diff;
    logic             fin_ok;
    logic             vco_ok;

    always_comb begin
        vco    = VCO_W'(fin) * VCO_W'(m);
        post   = vco >> pi;
        diff   = abs_diff(post, VCO_W'(tgt));
        fin_ok = fin >= HZ_W'(FIN_MIN_HZ);
        vco_ok = (vco >= VCO_W'(VCO_MIN_HZ)) && (vco <= VCO_W'(VCO_MAX_HZ));
        valid  = fin_ok && vco_ok;

        cand.d      = d;
        cand.pi     = pi;
        cand.m      = m;
        cand.out_hz = post[HZ_W-1:0];
        cand.err    = ERR_W'(diff);

        exact      = valid && (diff == '0);
        within_tol = valid && (diff <= VCO_W'(TOL_HZ));
    end

endmodule

// File: rtl/pll_best_track.sv
module pll_best_track
    import pll_search_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  upd_en,
    input  logic  cand_ok,
    input  cand_t cand,
    output logic  have,
    output cand_t best,
    output logic  have_nxt,
    output cand_t best_nxt
);

    logic take;

    always_comb begin
        take     = upd_en && cand_ok && (!have || (cand.err < best.err));
        have_nxt = have || take;
        best_nxt = take ? cand : best;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have <= 1'b0;
            best <= '0;
        end else begin
            have <= have_nxt;
            best <= best_nxt;
        end
    end

    AST_BEST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        $past(have) && !$past(clear) && have |-> (best.err <= $past(best.err))); // R7

endmodule

// File: rtl/pll_ratio_search.sv
module pll_ratio_search
    import pll_search_pkg::*;
#(
    parameter int D_MAX      = 64,
    parameter int M_MAX      = 1024,
    parameter int P_CNT      = 4,
    parameter int VCO_MIN_HZ = DEF_VCO_MIN_HZ,
    parameter int VCO_MAX_HZ = DEF_VCO_MAX_HZ,
    parameter int FIN_MIN_HZ = DEF_FIN_MIN_HZ,
    parameter int TOL_HZ     = DEF_TOL_HZ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       cfg_mode,
    input  logic [HZ_W-1:0]   cfg_freq_hz,
    input  logic [HZ_W-1:0]   ref_hz,
    output logic              busy,
    output logic              done,
    output logic              res_exact,
    output logic              res_near,
    output logic              res_fail,
    output logic              res_bypass,
    output logic              res_external,
    output logic [D_W-1:0]    div_d,
    output logic [M_W-1:0]    mul_m,
    output logic [POST_W-1:0] post_p,
    output logic [HZ_W-1:0]   out_hz
);

    scan_state_e  state;
    result_kind_e kind;
    logic [HZ_W-1:0] ref_q;
    logic [HZ_W-1:0] tgt_q;

    logic [D_W-1:0]  it_d;
    logic [PI_W-1:0] it_pi;
    logic [M_W-1:0]  it_m;
    logic [HZ_W-1:0] it_fin;
    logic            it_last;

    cand_t cur;
    logic  cur_valid;
    logic  cur_exact;
    logic  cur_ok;

    logic  bt_have;
    cand_t bt_best;
    logic  bt_have_nxt;
    cand_t bt_best_nxt;

    logic         load;
    logic         scanning;
    logic         fin_go;
    result_kind_e fin_kind;
    cand_t        fin_c;

    always_comb begin
        scanning = (state == ST_SCAN);
        load     = (state == ST_IDLE) && start && (cfg_mode == '0) && (cfg_freq_hz != '0);
        fin_go   = 1'b0;
        fin_kind = RK_NONE;
        fin_c    = '0;
        if (state == ST_IDLE) begin
            if (start && (cfg_mode != '0)) begin
                fin_go   = 1'b1;
                fin_kind = RK_BYPASS;
            end else if (start && (cfg_freq_hz == '0)) begin
                fin_go   = 1'b1;
                fin_kind = RK_EXTERNAL;
            end
        end else begin
            if (cur_exact) begin
                fin_go   = 1'b1;
                fin_kind = RK_EXACT;
                fin_c    = cur;
            end else if (it_last) begin
                fin_go = 1'b1;
                if (bt_have_nxt) begin
                    fin_kind = RK_NEAR;
                    fin_c    = bt_best_nxt;
                end else begin
                    fin_kind = RK_FAIL;
                end
            end
        end
    end

    pll_cand_iter #(
        .D_MAX (D_MAX),
        .M_MAX (M_MAX),
        .P_CNT (P_CNT)
    ) u_iter (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (scanning),
        .ref_now (ref_hz),
        .ref_q   (ref_q),
        .d       (it_d),
        .pi      (it_pi),
        .m       (it_m),
        .fin     (it_fin),
        .last    (it_last)
    );

    pll_cand_eval #(
        .VCO_MIN_HZ (VCO_MIN_HZ),
        .VCO_MAX_HZ (VCO_MAX_HZ),
        .FIN_MIN_HZ (FIN_MIN_HZ),
        .TOL_HZ     (TOL_HZ)
    ) u_eval (
        .fin        (it_fin),
        .d          (it_d),
        .pi         (it_pi),
        .m          (it_m),
        .tgt        (tgt_q),
        .cand       (cur),
        .valid      (cur_valid),
        .exact      (cur_exact),
        .within_tol (cur_ok)
    );

    pll_best_track u_best (
        .clk      (clk),
        .rst      (rst),
        .clear    (load),
        .upd_en   (scanning),
        .cand_ok  (cur_ok),
        .cand     (cur),
        .have     (bt_have),
        .best     (bt_best),
        .have_nxt (bt_have_nxt),
        .best_nxt (bt_best_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind   <= RK_NONE;
            done   <= 1'b0;
            ref_q  <= '0;
            tgt_q  <= '0;
            div_d  <= '0;
            mul_m  <= '0;
            post_p <= '0;
            out_hz <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state <= ST_SCAN;
                ref_q <= ref_hz;
                tgt_q <= cfg_freq_hz;
            end
            if (fin_go) begin
                state  <= ST_IDLE;
                done   <= 1'b1;
                kind   <= fin_kind;
                div_d  <= fin_c.d;
                mul_m  <= fin_c.m;
                out_hz <= fin_c.out_hz;
                post_p <= ((fin_kind == RK_EXACT) || (fin_kind == RK_NEAR))
                          ? (POST_W'(1) << fin_c.pi) : '0;
            end
        end
    end

    always_comb begin
        busy         = scanning;
        res_exact    = (kind == RK_EXACT);
        res_near     = (kind == RK_NEAR);
        res_fail     = (kind == RK_FAIL);
        res_bypass   = (kind == RK_BYPASS);
        res_external = (kind == RK_EXTERNAL);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(div_d) && $stable(mul_m) && $stable(post_p) && $stable(out_hz)); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_exact, res_near, res_fail, res_bypass, res_external})); // R9

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && res_fail |-> (div_d == '0) && (mul_m == '0) && (post_p == '0) && (out_hz == '0)); // R8

    AST_EXACT_HIT: assert property (@(posedge clk) disable iff (rst)
        done && res_exact |-> (out_hz == tgt_q)); // R6

    AST_NEAR_TOL: assert property (@(posedge clk) disable iff (rst)
        done && res_near |-> (abs_diff(VCO_W'(out_hz), VCO_W'(tgt_q)) <= VCO_W'(TOL_HZ))); // R7

    AST_VCO_LIMITS: assert property (@(posedge clk) disable iff (rst)
        done && (res_near || res_exact) |->
        ((VCO_W'(ref_q / HZ_W'(div_d)) * VCO_W'(mul_m)) >= VCO_W'(VCO_MIN_HZ)) &&
        ((VCO_W'(ref_q / HZ_W'(div_d)) * VCO_W'(mul_m)) <= VCO_W'(VCO_MAX_HZ))); // R4

    AST_SKIP_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        !busy && start && (cfg_mode != '0) |=> done && res_bypass); // R1

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> busy || done); // R10

endmodule

// File: tb/pll_ratio_search_test.sv
module pll_ratio_search_test;

    localparam int TB_D   = 8;
    localparam int TB_M   = 256;
    localparam int TB_P   = 4;
    localparam longint VMIN = 100_000_000;
    localparam longint VMAX = 350_000_000;
    localparam longint FMIN = 500_000;
    localparam longint TOL  = 500_000;
    localparam int N_CAND = TB_D * TB_P * TB_M;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cfg_mode = '0;
    logic [31:0] cfg_freq_hz = '0;
    logic [31:0] ref_hz = '0;
    logic        busy, done;
    logic        res_exact, res_near, res_fail, res_bypass, res_external;
    logic [6:0]  div_d;
    logic [10:0] mul_m;
    logic [3:0]  post_p;
    logic [31:0] out_hz;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    pll_ratio_search #(
        .D_MAX (TB_D),
        .M_MAX (TB_M),
        .P_CNT (TB_P)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_mode     (cfg_mode),
        .cfg_freq_hz  (cfg_freq_hz),
        .ref_hz       (ref_hz),
        .busy         (busy),
        .done         (done),
        .res_exact    (res_exact),
        .res_near     (res_near),
        .res_fail     (res_fail),
        .res_bypass   (res_bypass),
        .res_external (res_external),
        .div_d        (div_d),
        .mul_m        (mul_m),
        .post_p       (post_p),
        .out_hz       (out_hz)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150_000) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual %0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    // kind: 1 bypass, 2 external, 3 exact, 4 near, 5 fail
    task automatic model(input longint rf, input longint md, input longint fq,
                         output int lat, output int kind, output longint ed,
                         output longint em, output longint ep, output longint eo);
        longint best_err;
        bit     have;
        int     k;
        lat = 1; kind = 0; ed = 0; em = 0; ep = 0; eo = 0;
        if (md != 0) begin
            kind = 1;
            return;
        end
        if (fq == 0) begin
            kind = 2;
            return;
        end
        have = 0; best_err = 0; k = 0;
        for (int d = 1; d <= TB_D; d++) begin
            for (int p = 0; p < TB_P; p++) begin
                for (int m = 1; m <= TB_M; m++) begin
                    longint f, v, o, e;
                    bit ok;
                    f  = rf / d;
                    v  = f * m;
                    o  = v >>> p;
                    e  = (o > fq) ? o - fq : fq - o;
                    ok = (f >= FMIN) && (v >= VMIN) && (v <= VMAX);
                    if (ok && e == 0) begin
                        lat = k + 2; kind = 3;
                        ed = d; em = m; ep = longint'(1) << p; eo = o;
                        return;
                    end
                    if (ok && e <= TOL && (!have || e < best_err)) begin
                        have = 1; best_err = e;
                        ed = d; em = m; ep = longint'(1) << p; eo = o;
                    end
                    k++;
                end
            end
        end
        lat  = N_CAND + 1;
        kind = have ? 4 : 5;
    endtask

    task automatic run_case(input string rq_lat, input string rq_res,
                            input longint md, input longint fq, input longint rf,
                            input int poke);
        int lat, kind;
        longint ed, em, ep, eo;
        bit search;
        model(rf, md, fq, lat, kind, ed, em, ep, eo);
        search = (kind >= 3);
        @(negedge clk);
        cfg_mode    = 32'(md);
        cfg_freq_hz = 32'(fq);
        ref_hz      = 32'(rf);
        start       = 1'b1;
        for (int c = 1; c <= lat + 1; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (poke > 0 && c == poke) begin
                start = 1'b1; cfg_mode = 32'h7; cfg_freq_hz = 32'd1234; ref_hz = 32'd5;
            end
            if (poke > 0 && c == poke + 1) start = 1'b0;
            check(done == (c == lat), rq_lat, $sformatf("done at edge %0d", c),
                  longint'(done), longint'(c == lat));
            check(busy == (search && c < lat), rq_lat, $sformatf("busy at edge %0d", c),
                  longint'(busy), longint'(search && c < lat));
            if (c >= lat) begin
                string rq;
                rq = (c == lat) ? rq_res : "R9";
                check(res_bypass == (kind == 1), rq, "bypass flag", longint'(res_bypass), longint'(kind == 1));
                check(res_external == (kind == 2), rq, "external flag", longint'(res_external), longint'(kind == 2));
                check(res_exact == (kind == 3), rq, "exact flag", longint'(res_exact), longint'(kind == 3));
                check(res_near == (kind == 4), rq, "near flag", longint'(res_near), longint'(kind == 4));
                check(res_fail == (kind == 5), rq, "fail flag", longint'(res_fail), longint'(kind == 5));
                check(longint'(div_d) == ed, rq, "div_d", longint'(div_d), ed);
                check(longint'(mul_m) == em, rq, "mul_m", longint'(mul_m), em);
                check(longint'(post_p) == ep, rq, "post_p", longint'(post_p), ep);
                check(longint'(out_hz) == eo, rq, "out_hz", longint'(out_hz), eo);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(done == 1'b0 && busy == 1'b0, "R9", "done/busy after reset", longint'({done, busy}), 0);
        check({res_exact, res_near, res_fail, res_bypass, res_external} == '0, "R9",
              "flags after reset", longint'({res_exact, res_near, res_fail, res_bypass, res_external}), 0);
        check(div_d == '0 && mul_m == '0 && post_p == '0 && out_hz == '0, "R9",
              "settings after reset", longint'(out_hz), 0);

        // R1: nonzero mode word skips the search
        run_case("R1", "R1", 32'h1, 50_000_000, 25_000_000, 0);
        // R2: both words zero -> clock handled elsewhere
        run_case("R2", "R2", 0, 0, 25_000_000, 0);
        // R3, R6: early exact hit
        run_case("R3", "R6", 0, 50_000_000, 25_000_000, 0);
        // R6: exact at a higher VCO
        run_case("R3", "R6", 0, 150_000_000, 3_000_000, 0);
        // R7: nearest within tolerance, full scan
        run_case("R3", "R7", 0, 333_333_333, 25_000_000, 0);
        // R4, R8: request beyond any VCO -> fail
        run_case("R3", "R8", 0, 1_000_000_000, 25_000_000, 0);
        // R4: request far below reachable outputs -> fail
        run_case("R3", "R4", 0, 2_000_000, 25_000_000, 0);
        // R5: exact hit only with an input below the minimum must be refused
        run_case("R3", "R5", 0, 102_862_500, 3_900_007, 0);
        // R7: odd reference, near or exact decided by the model
        run_case("R3", "R7", 0, 74_250_000, 27_000_001, 0);
        // R10: start and new words during a search are ignored
        run_case("R10", "R10", 0, 333_333_333, 25_000_000, 100);
        // R1 again after a search, bypass must overwrite previous settings
        run_case("R1", "R1", 32'hFFFF_0000, 0, 0, 0);

        summary();
        $finish;
    end

endmodule